// File: doc/BRIEF.md
# Profiling Identification Register Read Gate

This block sits beside the system-register read path of a processor core. It decides what happens when software asks to read the identification register that describes the core's statistical profiling unit. Each request is judged against the current privilege level, the presence and width of the hypervisor and monitor levels, the halt and secure-debug-disable state, the security state, a 2-bit profiling ownership field owned by the monitor, and the hypervisor trap controls.

Exactly one outcome is produced per request. The outcome is one of four:

- the 64-bit identification value;
- an undefined-instruction indication;
- a trap to the hypervisor level;
- a trap to the monitor level.

Either trap carries the exception class 0x18. The answer appears on the registered outputs in the cycle after the request strobe.

The identification value is assembled from parameters. These are the maximum record size code, the recommended interval code, the random-interval mode and two capability flags. Parameter codes outside the legal sets stop elaboration. A further option, `EARLY_MON_PRIO`, decides whether the halted-with-secure-debug-disable undefined case is tested before the hypervisor traps.

Top module: `prof_id_access_chk`

## Requirements
- R1: A response is presented in the cycle after the clock edge that sampled `req` high. Exactly one of `rsp_value_vld`, `rsp_undef`, `rsp_trap_hyp` and `rsp_trap_mon` is high in that cycle. All four are low in the cycle after an edge that sampled `req` low.
- R2: A request made at level 0 (`cur_lvl` = 2'b00) always yields `rsp_undef`.
- R3: A request made at level 3 (`cur_lvl` = 2'b11) always yields `rsp_value_vld`.
- R4: At level 1, a fine-grained hypervisor trap yields `rsp_trap_hyp`. It applies when all three of these hold:
  - `hyp_enabled` and `hyp_is64` are both high;
  - `fgt_read_trap` is high;
  - `mon_present` is low or `fgt_enable` is high.
- R5: At level 1, when no fine-grained trap applies but `hyp_enabled`, `hyp_is64` and `hyp_prof_trap` are all high, the result is `rsp_trap_hyp`.
- R6: At levels 1 and 2, once the earlier checks pass, an ownership check runs when `mon_present` and `mon_is64` are both high. In secure state (`nonsec` low), `own_field` must equal 2'b01. In non-secure state it must equal 2'b11.
  - A mismatch yields `rsp_undef` if `halted` and `sec_dbg_dis` are both high.
  - A mismatch otherwise yields `rsp_trap_mon`.
  - A request that passes every check yields `rsp_value_vld`.
- R7: At level 2 the hypervisor trap controls have no effect. Only the ownership check of R6 applies.
- R8: With `EARLY_MON_PRIO` = 1, an ownership mismatch while halted with `sec_dbg_dis` set yields `rsp_undef` ahead of the hypervisor traps at level 1. With `EARLY_MON_PRIO` = 0, the traps of R4 and R5 win in that case.
- R9: When `rsp_value_vld` is high, `rsp_value` carries the following fields:
  - bits 63:20 and bits 7:6 read as zero;
  - bits 19:16 hold the counter code 4'b0010;
  - bits 15:12 hold `MAX_REC_CODE`;
  - bits 11:8 hold `INTERVAL_CODE`;
  - bit 5 holds `RAND_AFTER_BASE`, bit 4 `LOAD_SRC`, bit 3 `ARCH_INST`;
  - bits 2:0 read as 3'b111.

  Otherwise `rsp_value` is zero.
- R10: `rsp_class` equals 6'h18 in a cycle where `rsp_trap_hyp` or `rsp_trap_mon` is high, and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Read request strobe |
| cur_lvl | input | 2 | Current privilege level of the request |
| hyp_enabled | input | 1 | Hypervisor level enabled in current security state |
| hyp_is64 | input | 1 | Hypervisor level runs the 64-bit execution state |
| mon_present | input | 1 | Monitor level implemented |
| mon_is64 | input | 1 | Monitor level runs the 64-bit execution state |
| halted | input | 1 | Core is in debug halt |
| sec_dbg_dis | input | 1 | Secure debug disabled |
| nonsec | input | 1 | Non-secure state bit |
| own_field | input | 2 | Profiling ownership field set by the monitor |
| fgt_enable | input | 1 | Monitor allows fine-grained hypervisor traps |
| fgt_read_trap | input | 1 | Hypervisor fine-grained read trap for this register |
| hyp_prof_trap | input | 1 | Hypervisor coarse profiling-register trap |
| rsp_value_vld | output | 1 | Read completes with the value |
| rsp_value | output | 64 | Identification value, zero unless valid |
| rsp_undef | output | 1 | Undefined-instruction outcome |
| rsp_trap_hyp | output | 1 | Trap to hypervisor level |
| rsp_trap_mon | output | 1 | Trap to monitor level |
| rsp_class | output | 6 | Exception class of a trap, zero otherwise |

## Verification
The bench builds two copies of the block side by side on identical stimulus. Both use `MAX_REC_CODE` = 4'b1011, `INTERVAL_CODE` = 4'b0011, `RAND_AFTER_BASE` = 1, `LOAD_SRC` = 0 and `ARCH_INST` = 1, so every value field holds a distinct, asymmetric pattern. One copy sets `EARLY_MON_PRIO` to 1 and the other to 0. Since every control input is a single bit or a 2-bit code, all 16384 input combinations are swept on both copies. Each request is followed by an idle cycle. This covers every priority collision, including the cases where the two orderings of R8 give different answers.

// File: rtl/prof_id_pkg.sv
package prof_id_pkg;

   typedef enum logic [1:0] {
      OUT_VALUE    = 2'd0,
      OUT_UNDEF    = 2'd1,
      OUT_TRAP_HYP = 2'd2,
      OUT_TRAP_MON = 2'd3
   } outcome_e;

   localparam int          CLASS_W       = 6;
   localparam int          ID_W          = 64;
   localparam logic [5:0]  TRAP_CLASS    = 6'h18;
   localparam logic [3:0]  COUNTER_CODE  = 4'b0010;

   // Level-3 ownership codes that permit access
   localparam logic [1:0]  OWN_OK_SECURE = 2'b01;
   localparam logic [1:0]  OWN_OK_NONSEC = 2'b11;

   typedef struct packed {
      logic       hyp_enabled;
      logic       hyp_is64;
      logic       mon_present;
      logic       mon_is64;
      logic       halted;
      logic       sec_dbg_dis;
      logic       nonsec;
      logic [1:0] own_field;
      logic       fgt_enable;
      logic       fgt_read_trap;
      logic       hyp_prof_trap;
   } access_ctx_t;

endpackage

// File: rtl/prof_id_value.sv
module prof_id_value
   import prof_id_pkg::*;
#(
   parameter logic [3:0] MAX_REC_CODE    = 4'b0110,
   parameter logic [3:0] INTERVAL_CODE   = 4'b0100,
   parameter bit         RAND_AFTER_BASE = 1'b0,
   parameter bit         LOAD_SRC        = 1'b1,
   parameter bit         ARCH_INST       = 1'b0
) (
   output logic [ID_W-1:0] id_value
);

   localparam int HI_ZERO_W = ID_W - 20;

   // R9: record size code must lie in 16 bytes .. 2 KB
   if ((MAX_REC_CODE < 4'b0100) || (MAX_REC_CODE > 4'b1011)) begin : g_bad_rec
      $error("MAX_REC_CODE outside 4'b0100..4'b1011");
   end

   // R9: interval code 0 or 2..8
   if ((INTERVAL_CODE == 4'b0001) || (INTERVAL_CODE > 4'b1000)) begin : g_bad_int
      $error("INTERVAL_CODE is a reserved code");
   end

   assign id_value = {{HI_ZERO_W{1'b0}},
                      COUNTER_CODE,
                      MAX_REC_CODE,
                      INTERVAL_CODE,
                      2'b00,
                      RAND_AFTER_BASE,
                      LOAD_SRC,
                      ARCH_INST,
                      3'b111};

endmodule

// File: rtl/prof_id_owner_gate.sv
module prof_id_owner_gate
   import prof_id_pkg::*;
(
   input  access_ctx_t ctx,
   output logic        own_blocked,
   output logic        halt_sdd
);

   logic mon_checks;
   logic own_match;

   assign mon_checks  = ctx.mon_present & ctx.mon_is64;
   assign own_match   = ctx.nonsec ? (ctx.own_field == OWN_OK_NONSEC)
                                   : (ctx.own_field == OWN_OK_SECURE);
   assign own_blocked = mon_checks & ~own_match;
   assign halt_sdd    = ctx.halted & ctx.sec_dbg_dis;

endmodule

// File: rtl/prof_id_decide.sv
module prof_id_decide
   import prof_id_pkg::*;
#(
   parameter bit EARLY_MON_PRIO = 1'b0
) (
   input  logic [1:0]  cur_lvl,
   input  access_ctx_t ctx,
   input  logic        own_blocked,
   input  logic        halt_sdd,
   output outcome_e    outcome
);

   logic hyp_ok;
   logic fine_trap;
   logic coarse_trap;
   logic early_undef;
   logic late_result_undef;

   assign hyp_ok      = ctx.hyp_enabled & ctx.hyp_is64;
   assign fine_trap   = hyp_ok & (~ctx.mon_present | ctx.fgt_enable) & ctx.fgt_read_trap;
   assign coarse_trap = hyp_ok & ctx.hyp_prof_trap;
   assign late_result_undef = halt_sdd;

   if (EARLY_MON_PRIO) begin : g_early
      assign early_undef = own_blocked & halt_sdd;
   end else begin : g_late
      assign early_undef = 1'b0;
   end

   always_comb begin
      outcome = OUT_VALUE;
      unique case (cur_lvl)
         2'd0: outcome = OUT_UNDEF;
         2'd1: begin
            if (early_undef)                   outcome = OUT_UNDEF;
            else if (fine_trap || coarse_trap) outcome = OUT_TRAP_HYP;
            else if (own_blocked)              outcome = late_result_undef ? OUT_UNDEF : OUT_TRAP_MON;
            else                               outcome = OUT_VALUE;
         end
         2'd2: begin
            if (early_undef)                   outcome = OUT_UNDEF;
            else if (own_blocked)              outcome = late_result_undef ? OUT_UNDEF : OUT_TRAP_MON;
            else                               outcome = OUT_VALUE;
         end
         default: outcome = OUT_VALUE;
      endcase
   end

endmodule

// File: rtl/prof_id_access_chk.sv
module prof_id_access_chk
   import prof_id_pkg::*;
#(
   parameter logic [3:0] MAX_REC_CODE    = 4'b0110,
   parameter logic [3:0] INTERVAL_CODE   = 4'b0100,
   parameter bit         RAND_AFTER_BASE = 1'b0,
   parameter bit         LOAD_SRC        = 1'b1,
   parameter bit         ARCH_INST       = 1'b0,
   parameter bit         EARLY_MON_PRIO  = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   input  logic [1:0]  cur_lvl,
   input  logic        hyp_enabled,
   input  logic        hyp_is64,
   input  logic        mon_present,
   input  logic        mon_is64,
   input  logic        halted,
   input  logic        sec_dbg_dis,
   input  logic        nonsec,
   input  logic [1:0]  own_field,
   input  logic        fgt_enable,
   input  logic        fgt_read_trap,
   input  logic        hyp_prof_trap,
   output logic        rsp_value_vld,
   output logic [63:0] rsp_value,
   output logic        rsp_undef,
   output logic        rsp_trap_hyp,
   output logic        rsp_trap_mon,
   output logic [5:0]  rsp_class
);

   access_ctx_t     ctx;
   logic            own_blocked;
   logic            halt_sdd;
   outcome_e        outcome;
   logic [ID_W-1:0] id_value;
   logic [3:0]      flags_d;
   logic [3:0]      flags_q;

   assign ctx = '{hyp_enabled:   hyp_enabled,
                  hyp_is64:      hyp_is64,
                  mon_present:   mon_present,
                  mon_is64:      mon_is64,
                  halted:        halted,
                  sec_dbg_dis:   sec_dbg_dis,
                  nonsec:        nonsec,
                  own_field:     own_field,
                  fgt_enable:    fgt_enable,
                  fgt_read_trap: fgt_read_trap,
                  hyp_prof_trap: hyp_prof_trap};

   prof_id_value #(
      .MAX_REC_CODE    (MAX_REC_CODE),
      .INTERVAL_CODE   (INTERVAL_CODE),
      .RAND_AFTER_BASE (RAND_AFTER_BASE),
      .LOAD_SRC        (LOAD_SRC),
      .ARCH_INST       (ARCH_INST)
   ) u_value (
      .id_value (id_value)
   );

   prof_id_owner_gate u_owner (
      .ctx         (ctx),
      .own_blocked (own_blocked),
      .halt_sdd    (halt_sdd)
   );

   prof_id_decide #(
      .EARLY_MON_PRIO (EARLY_MON_PRIO)
   ) u_decide (
      .cur_lvl     (cur_lvl),
      .ctx         (ctx),
      .own_blocked (own_blocked),
      .halt_sdd    (halt_sdd),
      .outcome     (outcome)
   );

   // one-hot in order: value, undef, trap_hyp, trap_mon
   always_comb begin
      flags_d = 4'b0000;
      if (req) flags_d[outcome] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= 4'b0000;
      else        flags_q <= flags_d;
   end

   assign rsp_value_vld = flags_q[OUT_VALUE];
   assign rsp_undef     = flags_q[OUT_UNDEF];
   assign rsp_trap_hyp  = flags_q[OUT_TRAP_HYP];
   assign rsp_trap_mon  = flags_q[OUT_TRAP_MON];
   assign rsp_value     = rsp_value_vld ? id_value : '0;
   assign rsp_class     = (rsp_trap_hyp | rsp_trap_mon) ? TRAP_CLASS : '0;

endmodule

// File: rtl/prof_id_access_sva.sv
module prof_id_access_sva (
   input logic        clk,
   input logic        rst_n,
   input logic        req,
   input logic [1:0]  cur_lvl,
   input logic        rsp_value_vld,
   input logic [63:0] rsp_value,
   input logic        rsp_undef,
   input logic        rsp_trap_hyp,
   input logic        rsp_trap_mon,
   input logic [5:0]  rsp_class
);

   logic [3:0] flags;
   assign flags = {rsp_trap_mon, rsp_trap_hyp, rsp_undef, rsp_value_vld};

   // R1
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> ($countones(flags) == 1));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> (flags == 4'b0000));

   // R2
   lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && cur_lvl == 2'd0) |=> rsp_undef);

   // R3
   lvl3_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && cur_lvl == 2'd3) |=> rsp_value_vld);

   // R7
   lvl2_no_hyp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && cur_lvl == 2'd2) |=> !rsp_trap_hyp);

   // R9
   value_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_value_vld |-> (rsp_value[63:20] == '0 && rsp_value[7:6] == 2'b00
                         && rsp_value[2:0] == 3'b111));

   // R9
   value_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_value_vld |-> (rsp_value == '0));

   // R10
   class_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_trap_hyp || rsp_trap_mon) ? (rsp_class == 6'h18) : (rsp_class == 6'h00));

endmodule

bind prof_id_access_chk prof_id_access_sva u_sva (
   .clk           (clk),
   .rst_n         (rst_n),
   .req           (req),
   .cur_lvl       (cur_lvl),
   .rsp_value_vld (rsp_value_vld),
   .rsp_value     (rsp_value),
   .rsp_undef     (rsp_undef),
   .rsp_trap_hyp  (rsp_trap_hyp),
   .rsp_trap_mon  (rsp_trap_mon),
   .rsp_class     (rsp_class)
);

// File: tb/prof_id_access_chk_bench.sv
`timescale 1ns/1ps
module prof_id_access_chk_bench;

   localparam logic [3:0] T_REC  = 4'b1011;
   localparam logic [3:0] T_INT  = 4'b0011;
   localparam bit         T_RND  = 1'b1;
   localparam bit         T_LDS  = 1'b0;
   localparam bit         T_ARCH = 1'b1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [1:0]  cur_lvl = '0;
   logic        hyp_enabled = 1'b0, hyp_is64 = 1'b0, mon_present = 1'b0, mon_is64 = 1'b0;
   logic        halted = 1'b0, sec_dbg_dis = 1'b0, nonsec = 1'b0;
   logic [1:0]  own_field = '0;
   logic        fgt_enable = 1'b0, fgt_read_trap = 1'b0, hyp_prof_trap = 1'b0;

   logic        e_vld, e_und, e_th, e_tm;
   logic [63:0] e_val;
   logic [5:0]  e_cls;
   logic        l_vld, l_und, l_th, l_tm;
   logic [63:0] l_val;
   logic [5:0]  l_cls;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   prof_id_access_chk #(
      .MAX_REC_CODE (T_REC), .INTERVAL_CODE (T_INT), .RAND_AFTER_BASE (T_RND),
      .LOAD_SRC (T_LDS), .ARCH_INST (T_ARCH), .EARLY_MON_PRIO (1'b1)
   ) u_prof_id_access_chk (
      .clk (clk), .rst_n (rst_n), .req (req), .cur_lvl (cur_lvl),
      .hyp_enabled (hyp_enabled), .hyp_is64 (hyp_is64),
      .mon_present (mon_present), .mon_is64 (mon_is64),
      .halted (halted), .sec_dbg_dis (sec_dbg_dis), .nonsec (nonsec),
      .own_field (own_field), .fgt_enable (fgt_enable),
      .fgt_read_trap (fgt_read_trap), .hyp_prof_trap (hyp_prof_trap),
      .rsp_value_vld (e_vld), .rsp_value (e_val), .rsp_undef (e_und),
      .rsp_trap_hyp (e_th), .rsp_trap_mon (e_tm), .rsp_class (e_cls)
   );

   prof_id_access_chk #(
      .MAX_REC_CODE (T_REC), .INTERVAL_CODE (T_INT), .RAND_AFTER_BASE (T_RND),
      .LOAD_SRC (T_LDS), .ARCH_INST (T_ARCH), .EARLY_MON_PRIO (1'b0)
   ) u_prof_id_access_chk_late (
      .clk (clk), .rst_n (rst_n), .req (req), .cur_lvl (cur_lvl),
      .hyp_enabled (hyp_enabled), .hyp_is64 (hyp_is64),
      .mon_present (mon_present), .mon_is64 (mon_is64),
      .halted (halted), .sec_dbg_dis (sec_dbg_dis), .nonsec (nonsec),
      .own_field (own_field), .fgt_enable (fgt_enable),
      .fgt_read_trap (fgt_read_trap), .hyp_prof_trap (hyp_prof_trap),
      .rsp_value_vld (l_vld), .rsp_value (l_val), .rsp_undef (l_und),
      .rsp_trap_hyp (l_th), .rsp_trap_mon (l_tm), .rsp_class (l_cls)
   );

   // R9: expected identification value from field positions
   function automatic logic [63:0] exp_value();
      logic [63:0] v;
      v = 64'd0;
      v = v + (64'd2 << 16);
      v = v + (64'(T_REC) << 12);
      v = v + (64'(T_INT) << 8);
      v = v + (64'(T_RND) << 5) + (64'(T_LDS) << 4) + (64'(T_ARCH) << 3);
      v = v + 64'd7;
      return v;
   endfunction

   // 0 value, 1 undef, 2 trap hyp, 3 trap mon; tag names the deciding requirement
   function automatic int exp_outcome(input logic [13:0] s, input bit early, output string tag);
      logic [1:0] lv;
      bit hen, h64, mp, m64, hlt, sdd, ns, fen, ftr, ptr, blocked, hs, hyp_fine, hyp_coarse;
      logic [1:0] own;
      lv = s[13:12]; hen = s[11]; h64 = s[10]; mp = s[9]; m64 = s[8];
      hlt = s[7]; sdd = s[6]; ns = s[5]; own = s[4:3]; fen = s[2]; ftr = s[1]; ptr = s[0];
      blocked    = mp && m64 && (ns ? (own != 2'b11) : (own != 2'b01));
      hs         = hlt && sdd;
      hyp_fine   = hen && h64 && ftr && (!mp || fen);
      hyp_coarse = hen && h64 && ptr;
      if (lv == 2'd0) begin tag = "R2"; return 1; end
      if (lv == 2'd3) begin tag = "R3"; return 0; end
      if (early && blocked && hs) begin tag = "R8"; return 1; end
      if (lv == 2'd1) begin
         if (hyp_fine)   begin tag = (blocked && hs) ? "R8" : "R4"; return 2; end
         if (hyp_coarse) begin tag = (blocked && hs) ? "R8" : "R5"; return 2; end
      end
      tag = (lv == 2'd2) ? "R7" : "R6";
      if (blocked) return hs ? 1 : 3;
      return 0;
   endfunction

   task automatic check_rsp(input string who, input string tag, input int exp_k,
                            input logic vld, input logic und, input logic th, input logic tm,
                            input logic [63:0] val, input logic [5:0] cls);
      logic [3:0]  exp_f;
      logic [3:0]  got_f;
      logic [63:0] exp_v;
      logic [5:0]  exp_c;
      exp_f = (exp_k < 0) ? 4'b0000 : (4'b0001 << exp_k);
      got_f = {tm, th, und, vld};
      exp_v = (exp_k == 0) ? exp_value() : 64'd0;
      exp_c = (exp_k >= 2) ? 6'h18 : 6'h00;
      checks++;
      if (got_f != exp_f) begin
         fails++;
         $display("FAIL %s %s (R1 one outcome) flags actual=%b expected=%b", tag, who, got_f, exp_f);
      end else if (val != exp_v) begin
         fails++;
         $display("FAIL R9 %s value actual=%h expected=%h", who, val, exp_v);
      end else if (cls != exp_c) begin
         fails++;
         $display("FAIL R10 %s class actual=%h expected=%h", who, cls, exp_c);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired before sweep end");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      string tag_e, tag_l;
      int    k_e, k_l;
      repeat (3) @(negedge clk);
      // reset state (R1): all outcome flags low, value and class zero
      check_rsp("early", "R1", -1, e_vld, e_und, e_th, e_tm, e_val, e_cls);
      check_rsp("late",  "R1", -1, l_vld, l_und, l_th, l_tm, l_val, l_cls);
      rst_n = 1'b1;
      for (int s = 0; s < 16384; s++) begin
         @(negedge clk);
         {cur_lvl, hyp_enabled, hyp_is64, mon_present, mon_is64, halted, sec_dbg_dis,
          nonsec, own_field, fgt_enable, fgt_read_trap, hyp_prof_trap} = 14'(s);
         req = 1'b1;
         @(negedge clk);
         k_e = exp_outcome(14'(s), 1'b1, tag_e);
         k_l = exp_outcome(14'(s), 1'b0, tag_l);
         check_rsp("early", tag_e, k_e, e_vld, e_und, e_th, e_tm, e_val, e_cls);
         check_rsp("late",  tag_l, k_l, l_vld, l_und, l_th, l_tm, l_val, l_cls);
         req = 1'b0;
         // inputs stay put while idle; no response may appear (R1)
         @(negedge clk);
         check_rsp("early", "R1", -1, e_vld, e_und, e_th, e_tm, e_val, e_cls);
         check_rsp("late",  "R1", -1, l_vld, l_und, l_th, l_tm, l_val, l_cls);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule